// File: doc/BRIEF.md
# Back-Pressure Handshake Node Controller

This block sequences one compute step inside a node that talks to its neighbours through sampled shared links. Every input link carries a data word and a toggle bit. The controller sees a new value on a link when the toggle bit differs from the copy it took the last time it consumed inputs. Each consumer of the node's result returns a toggle acknowledge. The controller sees that acknowledge as new when it differs from the copy taken at the last publication.

The controller alternates between two phases, and it acts only on cycles where the local tick qualifier is high. In the gathering phase it waits until every input link shows new data. On that tick it runs the compute step, which here is a registered wrapping sum of all inputs, into a holding register. On the same tick it toggles an acknowledge bit back to every producer. In the releasing phase it waits until every consumer has acknowledged. On that tick it copies the held result onto the published output, toggles the output's freshness bit and goes back to gathering. Because the result is never published on the tick that computes it, nodes chained this way see a one-step delay between them.

Top module: `bpn_node`

## Requirements
- R1: While `rst_n` is low at a clock edge, the node enters the gathering phase. It sets `pub_data` and the holding register to `RESET_VALUE`, and it clears `pub_alt`, `ack_out`, both strobes and every stored freshness copy to 0.
- R2: On a clock edge with `tick` low, no register changes, and `fire_stb` and `pub_stb` are 0 in the following cycle.
- R3: In the gathering phase, a tick fires the compute step only when every bit of `in_alt` differs from its stored copy. If any one link is not new, nothing happens.
- R4: A firing tick loads the wrapping sum (modulo 2^`DATA_W`) of all `in_data` words into the holding register. It also inverts every bit of `ack_out` and raises `fire_stb` for exactly one cycle.
- R5: After a firing and before the next publication, new input data causes no further firing and does not change `ack_out`.
- R6: In the releasing phase, a tick publishes only when every bit of `ack_in` differs from the copy stored at the last publication (0 after reset).
- R7: A publishing tick sets `pub_data` to the value computed by the most recent firing, inverts `pub_alt` and raises `pub_stb` for exactly one cycle. `pub_data` and `pub_alt` change at no other time except reset.
- R8: Firing and publication never happen on the same tick. Input data that arrives during the releasing phase fires at the first tick after the publication.
- R9: The stored copy of `in_alt` is taken only at firing. A link whose toggle bit flips twice between firings therefore counts as not new.
- R10: `fire_stb` and `pub_stb` are never high together, and neither is high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Local activation qualifier; the node acts only on edges where it is high |
| in_data | input | NUM_IN*DATA_W | Input link data words, link k in bits [k*DATA_W +: DATA_W] |
| in_alt | input | NUM_IN | Input link toggle bits, one per link |
| ack_in | input | NUM_OUT | Toggle acknowledges returned by consumers |
| ack_out | output | NUM_IN | Toggle acknowledges sent to producers |
| pub_data | output | DATA_W | Published result |
| pub_alt | output | 1 | Freshness toggle of the published result |
| fire_stb | output | 1 | One-cycle pulse after a compute firing |
| pub_stb | output | 1 | One-cycle pulse after a publication |

## Verification
The case hardest to reach from the ports is input data that turns new while the node is still waiting for acknowledges. The firing must then wait for the publication and follow it on the very next tick, never on the same one. The stimulus creates this by toggling every input during the releasing phase, then releasing the last missing acknowledge. A second hard case is a link whose toggle bit flips twice between firings and so must not count as new. The bench builds it by toggling one link twice while the others toggle once. Long runs with random tick gaps and random toggles then let a behavioural model catch any ordering slip cycle by cycle.

// File: rtl/bpn_pkg.sv
// Shared types for the back-pressure node controller.
// Assumes nothing beyond a two-phase handshake sequence.
package bpn_pkg;

    // Phase of the node: gather inputs, then release the held result.
    typedef enum logic {
        PH_GATHER  = 1'b0,
        PH_RELEASE = 1'b1
    } bpn_phase_e;

endpackage

// File: rtl/bpn_fresh_track.sv
// Freshness tracker for a group of toggle-bit links.
// Keeps one stored copy per link. A link is new while its current bit
// differs from the copy. The copy is refreshed only when capture is high.
// Assumes capture is already qualified by the local tick.
module bpn_fresh_track #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cur,
    input  logic             capture,
    output logic             all_fresh
);

    logic [WIDTH-1:0] seen_q;
    logic [WIDTH-1:0] diff;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_link
            // Store this link's toggle bit at each capture event.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    seen_q[gi] <= 1'b0;
                end else if (capture) begin
                    seen_q[gi] <= cur[gi];
                end
            end
            // Flag this link as new while its bit differs from the copy.
            always_comb begin
                diff[gi] = cur[gi] ^ seen_q[gi];
            end
        end
    endgenerate

    // Combine per-link flags: all links must be new.
    always_comb begin
        all_fresh = &diff;
    end

    // A capture must only happen when all links were new.
    AST_CAPTURE_ONLY_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> all_fresh);  // R3

endmodule

// File: rtl/bpn_compute.sv
// Stand-in compute step: a registered wrapping sum of all input words.
// The result sits in a holding register until the next load.
// Assumes load is asserted only on a firing tick.
module bpn_compute #(
    parameter int            NUM_IN      = 3,
    parameter int            DATA_W      = 8,
    parameter logic [DATA_W-1:0] RESET_VALUE = '0,
    localparam int           BUS_W       = NUM_IN * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  in_data,
    input  logic              load,
    output logic [DATA_W-1:0] hold
);

    logic [DATA_W-1:0] sum;

    // Add all input words, dropping carries beyond DATA_W bits.
    always_comb begin
        sum = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            sum = sum + in_data[k*DATA_W +: DATA_W];
        end
    end

    // Capture the sum on a firing; otherwise keep the held value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= RESET_VALUE;
        end else if (load) begin
            hold <= sum;
        end
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hold));  // R7

endmodule

// File: rtl/bpn_publish.sv
// Output register for the node's result, with its freshness toggle.
// Copies the held value out and inverts the toggle on each publish.
// Assumes publish is asserted only on a releasing tick.
module bpn_publish #(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] RESET_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              publish,
    input  logic [DATA_W-1:0] hold,
    output logic [DATA_W-1:0] pub_data,
    output logic              pub_alt,
    output logic              pub_stb
);

    // Load the result and toggle freshness on a publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_data <= RESET_VALUE;
            pub_alt  <= 1'b0;
        end else if (publish) begin
            pub_data <= hold;
            pub_alt  <= ~pub_alt;
        end
    end

    // One-cycle strobe following each publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_stb <= 1'b0;
        end else begin
            pub_stb <= publish;
        end
    end

    AST_ALT_FLIPS_ON_PUB: assert property (@(posedge clk) disable iff (!rst_n)
        pub_stb |-> (pub_alt != $past(pub_alt)));  // R7
    AST_DATA_STILL_NO_PUB: assert property (@(posedge clk) disable iff (!rst_n)
        !publish |=> ($stable(pub_data) && $stable(pub_alt)));  // R7

endmodule

// File: rtl/bpn_node.sv
// Back-pressure node controller top.
// Sequences gather and release phases on local ticks. Fires the compute
// step when all inputs are new, acknowledges producers by toggling, and
// publishes the held result once all consumers have acknowledged.
// Assumes inputs are stable around the clock edge and tick is synchronous.
module bpn_node
    import bpn_pkg::*;
#(
    parameter int                NUM_IN      = 3,
    parameter int                NUM_OUT     = 2,
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] RESET_VALUE = 8'hA5,
    localparam int               BUS_W       = NUM_IN * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [BUS_W-1:0]  in_data,
    input  logic [NUM_IN-1:0] in_alt,
    input  logic [NUM_OUT-1:0] ack_in,
    output logic [NUM_IN-1:0] ack_out,
    output logic [DATA_W-1:0] pub_data,
    output logic              pub_alt,
    output logic              fire_stb,
    output logic              pub_stb
);

    bpn_phase_e        phase_q;
    logic              in_new;
    logic              ack_new;
    logic              go_fire;
    logic              go_pub;
    logic [DATA_W-1:0] hold;

    // Decide this edge's action from phase, tick and link freshness.
    always_comb begin
        go_fire = tick && (phase_q == PH_GATHER)  && in_new;
        go_pub  = tick && (phase_q == PH_RELEASE) && ack_new;
    end

    // Phase sequencing: gather -> release on firing, back on publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_GATHER;
        end else if (go_fire) begin
            phase_q <= PH_RELEASE;
        end else if (go_pub) begin
            phase_q <= PH_GATHER;
        end
    end

    // Toggle every producer acknowledge once per consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_out <= '0;
        end else if (go_fire) begin
            ack_out <= ~ack_out;
        end
    end

    // One-cycle strobe following each firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_stb <= 1'b0;
        end else begin
            fire_stb <= go_fire;
        end
    end

    bpn_fresh_track #(.WIDTH(NUM_IN)) u_in_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (in_alt),
        .capture   (go_fire),
        .all_fresh (in_new)
    );

    bpn_fresh_track #(.WIDTH(NUM_OUT)) u_ack_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (ack_in),
        .capture   (go_pub),
        .all_fresh (ack_new)
    );

    bpn_compute #(
        .NUM_IN      (NUM_IN),
        .DATA_W      (DATA_W),
        .RESET_VALUE (RESET_VALUE)
    ) u_compute (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_data (in_data),
        .load    (go_fire),
        .hold    (hold)
    );

    bpn_publish #(
        .DATA_W      (DATA_W),
        .RESET_VALUE (RESET_VALUE)
    ) u_publish (
        .clk      (clk),
        .rst_n    (rst_n),
        .publish  (go_pub),
        .hold     (hold),
        .pub_data (pub_data),
        .pub_alt  (pub_alt),
        .pub_stb  (pub_stb)
    );

    AST_NO_TICK_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!fire_stb && !pub_stb && $stable(ack_out)));  // R2
    AST_ACK_FLIPS_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_stb |-> (ack_out == ~$past(ack_out)));  // R4
    AST_ACK_STILL_IN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RELEASE) |=> $stable(ack_out));  // R5
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_stb && pub_stb));  // R10
    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_stb |=> !fire_stb);  // R10
    AST_PUB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pub_stb |=> !pub_stb);  // R10
    AST_NEVER_BOTH_GO: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_fire && go_pub));  // R8

endmodule

// File: tb/sim_bpn_node.sv
// Bench for bpn_node: directed corner cases, then random ticks and toggles,
// with a behavioural model compared on every falling edge.
module sim_bpn_node;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 3;
    localparam int NO = 2;
    localparam int DW = 8;
    localparam logic [DW-1:0] RV = 8'hA5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            tick;
    logic [NI*DW-1:0] in_data;
    logic [NI-1:0]   in_alt;
    logic [NO-1:0]   ack_in;
    logic [NI-1:0]   ack_out;
    logic [DW-1:0]   pub_data;
    logic            pub_alt;
    logic            fire_stb;
    logic            pub_stb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state.
    int m_phase;
    int m_hold;
    int m_pub;
    int m_palt;
    int m_ack;
    int m_seen_in;
    int m_seen_ack;
    int m_fire;
    int m_pstb;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpn_node #(.NUM_IN(NI), .NUM_OUT(NO), .DATA_W(DW), .RESET_VALUE(RV)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .in_data  (in_data),
        .in_alt   (in_alt),
        .ack_in   (ack_in),
        .ack_out  (ack_out),
        .pub_data (pub_data),
        .pub_alt  (pub_alt),
        .fire_stb (fire_stb),
        .pub_stb  (pub_stb)
    );

    // Behavioural model advanced on each rising edge.
    always @(posedge clk) begin
        int s;
        m_fire = 0;
        m_pstb = 0;
        if (!rst_n) begin
            m_phase = 0; m_hold = RV; m_pub = RV; m_palt = 0;
            m_ack = 0; m_seen_in = 0; m_seen_ack = 0;
        end else if (tick) begin
            if (m_phase == 0 && ((int'(in_alt) ^ m_seen_in) == (1 << NI) - 1)) begin
                s = 0;
                for (int k = 0; k < NI; k++) s += int'(in_data[k*DW +: DW]);
                m_hold = s % 256;
                m_seen_in = int'(in_alt);
                m_ack = m_ack ^ ((1 << NI) - 1);
                m_fire = 1;
                m_phase = 1;
            end else if (m_phase == 1 && ((int'(ack_in) ^ m_seen_ack) == (1 << NO) - 1)) begin
                m_pub = m_hold;
                m_palt = 1 - m_palt;
                m_seen_ack = int'(ack_in);
                m_pstb = 1;
                m_phase = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model; call at a falling edge.
    task automatic cmp_all();
        chk("R7 pub_data", int'(pub_data), m_pub);
        chk("R7 pub_alt", int'(pub_alt), m_palt);
        chk("R4 ack_out", int'(ack_out), m_ack);
        chk("R3 fire_stb", int'(fire_stb), m_fire);
        chk("R6 pub_stb", int'(pub_stb), m_pstb);
        chk("R10 strobes", int'(fire_stb & pub_stb), 0);
    endtask

    task automatic step();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic set_word(input int k, input int v);
        in_data[k*DW +: DW] = v[DW-1:0];
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b1; in_data = '0; in_alt = '0; ack_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pub_data", int'(pub_data), int'(RV));
        chk("R1 pub_alt", int'(pub_alt), 0);
        chk("R1 ack_out", int'(ack_out), 0);
        chk("R1 strobes", int'(fire_stb | pub_stb), 0);

        // R2: new data but no tick -> nothing happens
        rst_n = 1'b1; tick = 1'b0;
        set_word(0, 1); set_word(1, 2); set_word(2, 3); in_alt = 3'b111;
        repeat (3) step();
        chk("R2 no fire without tick", int'(fire_stb), 0);

        // R4: tick fires; sum held, acks toggled
        tick = 1'b1;
        step();
        chk("R4 fire pulse", int'(fire_stb), 1);
        chk("R4 ack toggled", int'(ack_out), 7);
        step();
        chk("R10 fire single", int'(fire_stb), 0);

        // R6/R5: partial ack and new inputs during release -> no action
        ack_in = 2'b01;
        set_word(0, 10); set_word(1, 20); set_word(2, 30); in_alt = 3'b000;
        repeat (3) step();
        chk("R6 partial ack no pub", int'(pub_stb), 0);
        chk("R5 no refire", int'(ack_out), 7);

        // R7/R8: complete acks -> publish 6, then fire 60 on next tick
        ack_in = 2'b11;
        step();
        chk("R7 pub pulse", int'(pub_stb), 1);
        chk("R7 pub value", int'(pub_data), 6);
        chk("R8 no fire with pub", int'(fire_stb), 0);
        step();
        chk("R8 fire after pub", int'(fire_stb), 1);
        ack_in = 2'b00;
        step();
        chk("R7 second pub value", int'(pub_data), 60);

        // R9: link 0 toggles twice, others once -> not all new
        in_alt[0] = ~in_alt[0]; in_alt[1] = ~in_alt[1]; in_alt[2] = ~in_alt[2];
        tick = 1'b0;
        step();
        in_alt[0] = ~in_alt[0];
        tick = 1'b1;
        repeat (3) step();
        chk("R9 double toggle not new", int'(fire_stb), 0);
        chk("R9 ack unchanged", int'(ack_out), 0);

        // Random phase: gappy ticks, random toggles and data.
        for (int c = 0; c < 3000; c++) begin
            tick = ($urandom % 4) != 0;
            for (int k = 0; k < NI; k++) begin
                if (($urandom % 3) == 0) begin
                    in_alt[k] = ~in_alt[k];
                    set_word(k, $urandom % 256);
                end
            end
            for (int j = 0; j < NO; j++) begin
                if (($urandom % 3) == 0) ack_in[j] = ~ack_in[j];
            end
            if (c == 1500) rst_n = 1'b0;
            if (c == 1503) rst_n = 1'b1;
            step();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule